// File: doc/BRIEF.md
# Clocked Serial Port with Independent Transmit and Receive Channels

The block moves 8-bit frames over a clocked serial link. Transmit and receive are two separate channels, each with its own shift-clock pin and its own choice of role. A channel set as clock master makes the shift clock itself, from a divisor counter running on the system clock. A channel set as clock slave takes the shift clock from its pin, passes it through a two-flop synchronizer and acts on the edges it finds in the system clock domain.

On the line the clock idles high. Data leaves least significant bit first, changes after a falling edge and is taken on a rising edge. A write to the transmit side while it is idle starts a frame. A start pulse on the receive side either runs eight master clock pulses or arms the slave receiver. A finished reception is placed in a holding register with a full flag. An overrun flag marks a byte that arrived while the previous one had not been acknowledged.

Top module: `ssp_port`

## Requirements
- R1: After reset, txd_o, txc_o and rxc_o are 1; tx_busy_o, tx_done_o, rx_busy_o, rx_full_o, rx_overrun_o, txc_oe_o and rxc_oe_o are 0; rx_data_o is 0x00.
- R2: In transmit master mode, a tx_wr_i pulse seen while idle starts a frame at that clock edge. txc_o falls and txd_o shows bit 0 at that edge. Each shift-clock pulse is H cycles low followed by H cycles high. txd_o moves to the next bit, lowest bit first, at the same edge where txc_o falls. After the high half of the eighth pulse the frame ends.
- R3: The half period H is tx_div_i (or rx_div_i) captured at frame start, raised to 4 when smaller, so a shift-clock period is never shorter than 8 system clocks.
- R4: tx_wr_i while tx_busy_o is 1 is ignored, and rx_start_i while rx_busy_o is 1 is ignored.
- R5: At the end of a transmit frame, tx_busy_o falls, tx_done_o rises and txd_o returns to 1, all at the same edge. tx_done_o stays set until the next accepted write clears it.
- R6: In transmit slave mode, txd_o shows bit 0 from the write onward. It moves to the next bit on each synchronized falling edge of txc_i that follows a synchronized rising edge. The frame ends on the eighth synchronized rising edge.
- R7: In receive master mode, rx_start_i produces eight pulses on rxc_o, timed like R2, and rxd_i is sampled at the edge where rxc_o rises.
- R8: In receive slave mode, rx_start_i arms the receiver. After the first synchronized falling edge of rxc_i, each synchronized rising edge samples rxd_i delayed by the same two flops as the clock.
- R9: After the eighth sampled bit, rx_data_o holds the byte with the first received bit in bit 0. rx_full_o is set and rx_busy_o is cleared at the same edge.
- R10: A byte loaded while rx_full_o is 1 and rx_ack_i is 0 sets rx_overrun_o. rx_ack_i clears rx_full_o and rx_overrun_o when no byte is loaded in that cycle.
- R11: txc_oe_o and rxc_oe_o are 1 when the channel is in master mode. The mode follows the mode input while the channel is idle and is held during a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_master_i | input | 1 | Transmit role: 1 master, 0 slave |
| tx_div_i | input | 8 | Transmit half-period divisor |
| tx_wr_i | input | 1 | Transmit data write strobe |
| tx_data_i | input | 8 | Byte to send |
| tx_busy_o | output | 1 | Transmit frame in progress |
| tx_done_o | output | 1 | Transmit frame completed |
| txd_o | output | 1 | Serial transmit data |
| txc_o | output | 1 | Transmit shift clock when master |
| txc_oe_o | output | 1 | Drive enable for the transmit clock pin |
| txc_i | input | 1 | Transmit shift clock from the pin when slave |
| rx_master_i | input | 1 | Receive role: 1 master, 0 slave |
| rx_div_i | input | 8 | Receive half-period divisor |
| rx_start_i | input | 1 | Start or arm a reception |
| rx_ack_i | input | 1 | Acknowledge the held byte |
| rx_busy_o | output | 1 | Reception in progress |
| rx_data_o | output | 8 | Last received byte |
| rx_full_o | output | 1 | Received byte waiting |
| rx_overrun_o | output | 1 | Byte arrived while one was still waiting |
| rxd_i | input | 1 | Serial receive data |
| rxc_o | output | 1 | Receive shift clock when master |
| rxc_oe_o | output | 1 | Drive enable for the receive clock pin |
| rxc_i | input | 1 | Receive shift clock from the pin when slave |

## Verification
A wrong bit index or a wrong shift direction shows up on txd_o within one half period of the bad edge. It shows up on rx_data_o only when the frame ends, so the per-cycle comparison of the pins finds transmit faults sooner than receive faults. A divisor counter that is off by one changes how long txc_o or rxc_o stays low at the first pulse, which is at most four to a few dozen cycles after start. A slave-mode synchronizer with wrong depth or wrong reset moves each data change by a cycle, or makes a false edge that starts a shift early. Both are seen on txd_o or on the sampled byte in the same frame. Flag faults such as a lost overrun or a full flag not cleared by acknowledge appear at the first load after the fault.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int DATA_W      = 8;
    localparam int DIV_W       = 8;
    localparam int MIN_HALF    = 4;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic [DIV_W-1:0] eff_half(input logic [DIV_W-1:0] d);
        return (d < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : d;
    endfunction

endpackage

// File: rtl/ssp_brg.sv
module ssp_brg
    import ssp_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         run_i,
    input  logic [W-1:0] half_i,
    output logic         tick_o
);
    logic [W-1:0] half_q;
    logic [W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == half_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= W'(MIN_HALF);
            cnt_q  <= '0;
        end else if (load_i) begin
            half_q <= (half_i < W'(MIN_HALF)) ? W'(MIN_HALF) : half_i;
            cnt_q  <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ssp_sync.sv
module ssp_sync
    import ssp_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_i,
    output edge_t ev_o
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-1:0], pin_i};
    end

    assign ev_o.rise =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign ev_o.fall = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
    import ssp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int VW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          master_i,
    input  logic          wr_i,
    input  logic [DW-1:0] data_i,
    input  logic [VW-1:0] div_i,
    input  edge_t         ev_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          sd_o,
    output logic          sck_o,
    output logic          sck_oe_o
);
    localparam int BW = $clog2(DW);
    localparam logic [BW-1:0] LAST = BW'(DW - 1);

    logic          busy_q, done_q, sd_q, sck_q, master_q, armed_q;
    logic [BW-1:0] bit_q, bit_nx;
    logic [DW-1:0] sh_q;
    logic          start, tick;

    assign start  = wr_i & ~busy_q;
    assign bit_nx = bit_q + 1'b1;

    ssp_brg #(.W(VW)) u_brg (
        .clk(clk), .rst(rst), .load_i(start), .run_i(busy_q & master_q),
        .half_i(div_i), .tick_o(tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0; done_q <= 1'b0; sd_q <= 1'b1; sck_q <= 1'b1;
            master_q <= 1'b0; armed_q <= 1'b0; bit_q <= '0; sh_q <= '0;
        end else if (start) begin
            busy_q   <= 1'b1;
            done_q   <= 1'b0;
            master_q <= master_i;
            sh_q     <= data_i;
            bit_q    <= '0;
            armed_q  <= 1'b0;
            sd_q     <= data_i[0];
            sck_q    <= ~master_i;
        end else if (!busy_q) begin
            master_q <= master_i;
        end else if (master_q) begin
            if (tick) begin
                if (!sck_q) begin
                    sck_q <= 1'b1;
                end else if (bit_q == LAST) begin
                    busy_q <= 1'b0; done_q <= 1'b1; sd_q <= 1'b1;
                end else begin
                    bit_q <= bit_nx; sd_q <= sh_q[bit_nx]; sck_q <= 1'b0;
                end
            end
        end else begin
            if (ev_i.rise) begin
                if (bit_q == LAST) begin
                    busy_q <= 1'b0; done_q <= 1'b1; sd_q <= 1'b1;
                end else begin
                    armed_q <= 1'b1;
                end
            end else if (ev_i.fall && armed_q) begin
                bit_q <= bit_nx; sd_q <= sh_q[bit_nx]; armed_q <= 1'b0;
            end
        end
    end

    assign busy_o   = busy_q;
    assign done_o   = done_q;
    assign sd_o     = sd_q;
    assign sck_o    = sck_q;
    assign sck_oe_o = master_q;
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
    import ssp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int VW = DIV_W,
    parameter int SS = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          master_i,
    input  logic          start_i,
    input  logic          ack_i,
    input  logic [VW-1:0] div_i,
    input  edge_t         ev_i,
    input  logic          sd_i,
    output logic          busy_o,
    output logic [DW-1:0] data_o,
    output logic          full_o,
    output logic          ovr_o,
    output logic          sck_o,
    output logic          sck_oe_o
);
    localparam int BW = $clog2(DW);
    localparam logic [BW-1:0] LAST = BW'(DW - 1);

    logic          busy_q, sck_q, master_q, armed_q, full_q, ovr_q;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] sh_q, data_q;
    logic [SS-1:0] dly_q;
    logic          start, tick, sample, load, din;

    assign start  = start_i & ~busy_q;
    assign din    = master_q ? sd_i : dly_q[SS-1];
    assign sample = busy_q & ~start &
                    (master_q ? (tick & ~sck_q) : (ev_i.rise & armed_q));
    assign load   = sample && (bit_q == LAST);

    ssp_brg #(.W(VW)) u_brg (
        .clk(clk), .rst(rst), .load_i(start), .run_i(busy_q & master_q),
        .half_i(div_i), .tick_o(tick)
    );

    always_ff @(posedge clk) begin
        if (rst) dly_q <= '1;
        else     dly_q <= {dly_q[SS-2:0], sd_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0; sck_q <= 1'b1; master_q <= 1'b0; armed_q <= 1'b0;
            bit_q <= '0; sh_q <= '0;
        end else if (start) begin
            busy_q   <= 1'b1;
            master_q <= master_i;
            bit_q    <= '0;
            armed_q  <= 1'b0;
            sck_q    <= ~master_i;
        end else if (!busy_q) begin
            master_q <= master_i;
        end else begin
            if (master_q && tick) sck_q <= ~sck_q;
            if (!master_q && ev_i.fall) armed_q <= 1'b1;
            if (sample) begin
                sh_q <= {din, sh_q[DW-1:1]};
                if (bit_q == LAST) busy_q <= 1'b0;
                else               bit_q  <= bit_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0; full_q <= 1'b0; ovr_q <= 1'b0;
        end else if (load) begin
            data_q <= {din, sh_q[DW-1:1]};
            full_q <= 1'b1;
            ovr_q  <= (ovr_q | full_q) & ~ack_i;
        end else if (ack_i) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end
    end

    assign busy_o   = busy_q;
    assign data_o   = data_q;
    assign full_o   = full_q;
    assign ovr_o    = ovr_q;
    assign sck_o    = sck_q;
    assign sck_oe_o = master_q;
endmodule

// File: rtl/ssp_port.sv
module ssp_port
    import ssp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int VW = DIV_W,
    parameter int SS = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_master_i,
    input  logic [VW-1:0] tx_div_i,
    input  logic          tx_wr_i,
    input  logic [DW-1:0] tx_data_i,
    output logic          tx_busy_o,
    output logic          tx_done_o,
    output logic          txd_o,
    output logic          txc_o,
    output logic          txc_oe_o,
    input  logic          txc_i,
    input  logic          rx_master_i,
    input  logic [VW-1:0] rx_div_i,
    input  logic          rx_start_i,
    input  logic          rx_ack_i,
    output logic          rx_busy_o,
    output logic [DW-1:0] rx_data_o,
    output logic          rx_full_o,
    output logic          rx_overrun_o,
    input  logic          rxd_i,
    output logic          rxc_o,
    output logic          rxc_oe_o,
    input  logic          rxc_i
);
    edge_t tx_ev, rx_ev;

    ssp_sync #(.STAGES(SS)) u_tx_sync (.clk(clk), .rst(rst), .pin_i(txc_i), .ev_o(tx_ev));
    ssp_sync #(.STAGES(SS)) u_rx_sync (.clk(clk), .rst(rst), .pin_i(rxc_i), .ev_o(rx_ev));

    ssp_tx #(.DW(DW), .VW(VW)) u_tx (
        .clk(clk), .rst(rst), .master_i(tx_master_i), .wr_i(tx_wr_i),
        .data_i(tx_data_i), .div_i(tx_div_i), .ev_i(tx_ev),
        .busy_o(tx_busy_o), .done_o(tx_done_o), .sd_o(txd_o),
        .sck_o(txc_o), .sck_oe_o(txc_oe_o)
    );

    ssp_rx #(.DW(DW), .VW(VW), .SS(SS)) u_rx (
        .clk(clk), .rst(rst), .master_i(rx_master_i), .start_i(rx_start_i),
        .ack_i(rx_ack_i), .div_i(rx_div_i), .ev_i(rx_ev), .sd_i(rxd_i),
        .busy_o(rx_busy_o), .data_o(rx_data_o), .full_o(rx_full_o),
        .ovr_o(rx_overrun_o), .sck_o(rxc_o), .sck_oe_o(rxc_oe_o)
    );
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk
    import ssp_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic tx_busy_o,
    input logic tx_done_o,
    input logic txd_o,
    input logic txc_o,
    input logic rx_busy_o,
    input logic rx_full_o,
    input logic rx_overrun_o,
    input logic rxc_o
);
    logic [15:0] tx_low, rx_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_low <= '0;
            rx_low <= '0;
        end else begin
            tx_low <= txc_o ? 16'd0 : ((tx_low == 16'hFFFF) ? tx_low : tx_low + 16'd1);
            rx_low <= rxc_o ? 16'd0 : ((rx_low == 16'hFFFF) ? rx_low : rx_low + 16'd1);
        end
    end

    p_tx_low_half_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(txc_o) |-> (tx_low >= 16'(MIN_HALF)));

    p_rx_low_half_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rxc_o) |-> (rx_low >= 16'(MIN_HALF)));

    p_idle_lines_r5: assert property (@(posedge clk) disable iff (rst)
        !tx_busy_o |-> (txd_o && txc_o));

    p_done_at_end_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done_o) |-> $fell(tx_busy_o));

    p_no_done_while_busy_r5: assert property (@(posedge clk) disable iff (rst)
        tx_busy_o |-> !tx_done_o);

    p_full_when_loaded_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full_o) |-> !rx_busy_o);

    p_overrun_needs_full_r10: assert property (@(posedge clk) disable iff (rst)
        rx_overrun_o |-> rx_full_o);
endmodule

bind ssp_port ssp_port_chk u_chk (
    .clk(clk), .rst(rst), .tx_busy_o(tx_busy_o), .tx_done_o(tx_done_o),
    .txd_o(txd_o), .txc_o(txc_o), .rx_busy_o(rx_busy_o), .rx_full_o(rx_full_o),
    .rx_overrun_o(rx_overrun_o), .rxc_o(rxc_o)
);

// File: tb/ssp_port_bench.sv
`timescale 1ns/1ps
module ssp_port_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       tx_master = 1'b1, tx_wr = 1'b0, rx_master = 1'b0, rx_start = 1'b0, rx_ack = 1'b0;
    logic [7:0] tx_div = 8'd4, rx_div = 8'd4, tx_data = 8'h00;
    logic       loop_mode = 1'b0;
    logic       tx_busy, tx_done, txd, txc, txc_oe, rx_busy, rx_full, rx_ovr, rxc, rxc_oe;
    logic [7:0] rx_data;
    logic       txc_in, rxc_in, rxd_in;

    assign txc_in = loop_mode ? rxc : 1'b1;
    assign rxc_in = loop_mode ? 1'b1 : txc;
    assign rxd_in = txd;

    ssp_port u_ssp_port (
        .clk(clk), .rst(rst), .tx_master_i(tx_master), .tx_div_i(tx_div),
        .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_busy_o(tx_busy), .tx_done_o(tx_done),
        .txd_o(txd), .txc_o(txc), .txc_oe_o(txc_oe), .txc_i(txc_in),
        .rx_master_i(rx_master), .rx_div_i(rx_div), .rx_start_i(rx_start),
        .rx_ack_i(rx_ack), .rx_busy_o(rx_busy), .rx_data_o(rx_data),
        .rx_full_o(rx_full), .rx_overrun_o(rx_ovr), .rxd_i(rxd_in),
        .rxc_o(rxc), .rxc_oe_o(rxc_oe), .rxc_i(rxc_in)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    // Behavioural reference model, stepped at each falling clock edge to
    // predict the state after the next rising edge.
    bit t_busy = 0, t_done = 0, t_txd = 1, t_txc = 1, t_mast = 0, t_armed = 0;
    int t_hc = 0, t_half = 4, t_bit = 0;
    bit [7:0] t_sh = 0;
    bit ts0 = 1, ts1 = 1, ts2 = 1;
    bit r_busy = 0, r_mast = 0, r_rxc = 1, r_armed = 0, r_full = 0, r_ovr = 0;
    int r_hc = 0, r_half = 4, r_bit = 0;
    bit [7:0] r_sh = 0, r_data = 0;
    bit rs0 = 1, rs1 = 1, rs2 = 1, rp0 = 1, rp1 = 1;
    int shown = 0;

    always @(negedge clk) begin
        logic [17:0] expv, gotv;
        bit t_rise, t_fall, r_rise, r_fall, smp, ld, din;
        expv = {t_txd, t_txc, t_mast, t_busy, t_done, r_rxc, r_mast, r_busy, r_data, r_full, r_ovr};
        gotv = {txd, txc, txc_oe, tx_busy, tx_done, rxc, rxc_oe, rx_busy, rx_data, rx_full, rx_ovr};
        checks++;
        if (expv !== gotv) begin
            failures++;
            if (shown < 10) $display("FAIL per-cycle model R2 R6 R7 R8 R11 got=0x%0h exp=0x%0h", gotv, expv);
            shown++;
        end
        t_rise = ts1 && !ts2; t_fall = !ts1 && ts2;
        r_rise = rs1 && !rs2; r_fall = !rs1 && rs2;
        if (rst) begin
            t_busy = 0; t_done = 0; t_txd = 1; t_txc = 1; t_mast = 0; t_armed = 0; t_bit = 0; t_hc = 0;
            r_busy = 0; r_mast = 0; r_rxc = 1; r_armed = 0; r_full = 0; r_ovr = 0; r_data = 0; r_bit = 0; r_hc = 0;
            ts0 = 1; ts1 = 1; ts2 = 1; rs0 = 1; rs1 = 1; rs2 = 1; rp0 = 1; rp1 = 1;
        end else begin
            if (tx_wr && !t_busy) begin
                t_sh = tx_data; t_busy = 1; t_done = 0; t_mast = tx_master; t_bit = 0;
                t_armed = 0; t_txd = tx_data[0]; t_txc = !tx_master; t_hc = 0;
                t_half = (tx_div < 4) ? 4 : int'(tx_div);
            end else if (!t_busy) begin
                t_mast = tx_master;
            end else if (t_mast) begin
                if (t_hc == t_half - 1) begin
                    t_hc = 0;
                    if (!t_txc) t_txc = 1;
                    else if (t_bit == 7) begin t_busy = 0; t_done = 1; t_txd = 1; end
                    else begin t_bit++; t_txd = t_sh[t_bit]; t_txc = 0; end
                end else t_hc++;
            end else begin
                if (t_rise) begin
                    if (t_bit == 7) begin t_busy = 0; t_done = 1; t_txd = 1; end
                    else t_armed = 1;
                end else if (t_fall && t_armed) begin
                    t_bit++; t_txd = t_sh[t_bit]; t_armed = 0;
                end
            end
            smp = 0; ld = 0; din = 0;
            if (rx_start && !r_busy) begin
                r_busy = 1; r_mast = rx_master; r_bit = 0; r_armed = 0; r_rxc = !rx_master;
                r_hc = 0; r_half = (rx_div < 4) ? 4 : int'(rx_div);
            end else if (!r_busy) begin
                r_mast = rx_master;
            end else begin
                if (r_mast) begin
                    if (r_hc == r_half - 1) begin
                        r_hc = 0;
                        if (!r_rxc) begin r_rxc = 1; smp = 1; din = rxd_in; end
                        else r_rxc = 0;
                    end else r_hc++;
                end else begin
                    if (r_fall) r_armed = 1;
                    else if (r_rise && r_armed) begin smp = 1; din = rp1; end
                end
                if (smp) begin
                    r_sh[r_bit] = din;
                    if (r_bit == 7) begin ld = 1; r_busy = 0; r_data = r_sh; end
                    else r_bit++;
                end
            end
            if (ld) begin r_ovr = (r_ovr || r_full) && !rx_ack; r_full = 1; end
            else if (rx_ack) begin r_full = 0; r_ovr = 0; end
            ts2 = ts1; ts1 = ts0; ts0 = txc_in;
            rs2 = rs1; rs1 = rs0; rs0 = rxc_in;
            rp1 = rp0; rp0 = rxd_in;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog R2 run did not finish got=%0d exp=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick_in();
        @(posedge clk); #2;
    endtask

    task automatic write_tx(input logic [7:0] d);
        tick_in(); tx_wr = 1'b1; tx_data = d;
        tick_in(); tx_wr = 1'b0;
    endtask

    task automatic pulse_start();
        tick_in(); rx_start = 1'b1;
        tick_in(); rx_start = 1'b0;
    endtask

    task automatic pulse_ack();
        tick_in(); rx_ack = 1'b1;
        tick_in(); rx_ack = 1'b0;
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(txd && txc && rxc, "R1 idle lines", {txd, txc, rxc}, 3'b111);
        check(!tx_busy && !tx_done && !rx_busy, "R1 busy/done", {tx_busy, tx_done, rx_busy}, 0);
        check(!rx_full && !rx_ovr && rx_data == 8'h00, "R1 rx flags", {rx_full, rx_ovr, rx_data}, 0);

        // Transmit master to receive slave, byte 0xA5, plus a write while busy
        tx_master = 1'b1; rx_master = 1'b0; tx_div = 8'd4; loop_mode = 1'b0;
        pulse_start();
        @(negedge clk);
        check(txc_oe && !rxc_oe, "R11 oe per mode", {txc_oe, rxc_oe}, 2'b10);
        write_tx(8'hA5);
        @(negedge clk);
        check(tx_busy && !txc && txd == 1'b1, "R2 frame start", {tx_busy, txc, txd}, 3'b101);
        repeat (10) @(posedge clk);
        write_tx(8'h11);
        while (tx_busy) @(negedge clk);
        check(tx_done && txd, "R5 done and line high", {tx_done, txd}, 2'b11);
        repeat (8) @(negedge clk);
        check(rx_data == 8'hA5, "R2 R8 received byte", rx_data, 8'hA5);
        check(rx_full && !rx_busy, "R9 full after frame", {rx_full, rx_busy}, 2'b10);
        check(!rx_ovr, "R10 no overrun first byte", rx_ovr, 0);
        check(rx_data != 8'h11, "R4 write while busy ignored", rx_data, 8'hA5);

        // Divisor below floor, second byte without acknowledge
        tx_div = 8'd1;
        pulse_start();
        write_tx(8'h3C);
        n = 0;
        @(negedge clk);
        while (!txc) begin n++; @(negedge clk); end
        check(n == 4, "R3 half period floor", n, 4);
        while (tx_busy) @(negedge clk);
        repeat (8) @(negedge clk);
        check(rx_data == 8'h3C, "R8 second byte", rx_data, 8'h3C);
        check(rx_ovr && rx_full, "R10 overrun set", {rx_ovr, rx_full}, 2'b11);
        pulse_ack();
        @(negedge clk);
        check(!rx_ovr && !rx_full, "R10 ack clears", {rx_ovr, rx_full}, 0);

        // Receive master to transmit slave, byte 0x96
        loop_mode = 1'b1; tx_master = 1'b0; rx_master = 1'b1; rx_div = 8'd5;
        repeat (2) @(negedge clk);
        check(!txc_oe && rxc_oe, "R11 oe swapped", {txc_oe, rxc_oe}, 2'b01);
        write_tx(8'h96);
        @(negedge clk);
        check(txd == 1'b0 && tx_busy, "R6 slave first bit", {txd, tx_busy}, 2'b01);
        pulse_start();
        pulse_start();
        @(negedge clk);
        while (rx_busy) @(negedge clk);
        repeat (8) @(negedge clk);
        check(rx_data == 8'h96, "R7 master receive byte", rx_data, 8'h96);
        check(tx_done && !tx_busy, "R6 slave frame end", {tx_done, tx_busy}, 2'b10);
        check(rxc && rx_full, "R9 clock idle and full", {rxc, rx_full}, 2'b11);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule